// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner with Separate IRQ and FIQ Outputs

The block gathers a vector of level interrupt lines into two processor requests. The normal request and the fast request each have their own enable mask. Software changes a mask by writing ones to a set index or to a clear index, so one write never disturbs bits it does not name. Each output is high while any line that its mask enables is high. The outputs are combinational from the lines and the mask registers.

Line 0 is also the target of a software request bit. The level seen on line 0 is the OR of the external input and that bit. A register port reads the masked and the raw views of the lines. Read data arrives one cycle after the request. Accesses that the index map forbids are dropped, and `err_o` pulses high for one cycle. The output of one instance may drive a line of another instance to build a chain.

Top module: `lvl_intc`

## Requirements
- R1: Reading index 1 or index 9 returns the level vector. Bit 0 of that vector is the external line 0 ORed with the software request bit. Every other bit follows its input line.
- R2: `irq_o` is high exactly when level AND the IRQ mask is nonzero. `fiq_o` is high exactly when level AND the FIQ mask is nonzero. Both react combinationally to line changes.
- R3: A write to index 2 ORs the data into the IRQ mask. A write to index 3 clears the mask bits where the data holds ones. A read of index 2 returns the IRQ mask.
- R4: Indices 10 and 11 act on the FIQ mask the way indices 2 and 3 act on the IRQ mask. A read of index 10 returns the FIQ mask.
- R5: Reading index 0 returns level AND the IRQ mask. Reading index 8 returns level AND the FIQ mask.
- R6: A write to index 4 with data bit 0 set raises the software request bit. A write to index 5 with data bit 0 set lowers it. Reading index 4 returns the bit in data bit 0 and zeros above it.
- R7: After reset both masks and the software bit are zero, `irq_o`, `fiq_o`, `err_o` and `rvalid_o` are low, and reading index 2 or index 10 returns zero.
- R8: A write to index 0, 1, 8 or 9 changes no state, and `err_o` is high in the following cycle.
- R9: A read of index 3, 5 or 11 returns zero, and `err_o` is high in the following cycle.
- R10: Read data and `rvalid_o` appear in the cycle after the request. Indices 6, 7 and 12 to 15 read as zero, ignore writes, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | NUM_SRC | Level interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 4 | Word index (byte offset shifted right by two) |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| err_o | output | 1 | One-cycle pulse after a forbidden access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong mask bit shows on `irq_o` or `fiq_o` in the same cycle that its line is driven high. It also shows in the enable readback one cycle after the read request. A software bit stuck in the wrong state appears at once in raw bit 0 and on both outputs when bit 0 is enabled. A missed or extra write strobe is hard to see from the outputs alone, so the random stimulus reads the masks back and compares them with a bench model after every access. A forbidden access that leaks into state shows up at the next readback of that mask.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int IDX_W  = 4;
  localparam int NUM_CH = 2;  // 0: irq, 1: fiq

  localparam logic [IDX_W-1:0] IX_SOFT_SET = 4'd4;
  localparam logic [IDX_W-1:0] IX_SOFT_CLR = 4'd5;

  // per-channel offsets from the channel base
  localparam logic [IDX_W-1:0] OFF_STAT  = 4'd0;
  localparam logic [IDX_W-1:0] OFF_RAW   = 4'd1;
  localparam logic [IDX_W-1:0] OFF_ENSET = 4'd2;
  localparam logic [IDX_W-1:0] OFF_ENCLR = 4'd3;

  typedef struct packed {
    logic [NUM_CH-1:0] en_set;
    logic [NUM_CH-1:0] en_clr;
    logic              soft_set;
    logic              soft_clr;
    logic              bad;
  } strobe_t;

  function automatic logic [IDX_W-1:0] chan_base(input int c);
    return IDX_W'(c * 8);
  endfunction
endpackage

// File: rtl/lvl_intc_decode.sv
module lvl_intc_decode
  import lvl_intc_pkg::*;
(
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wbit0_i,
  output strobe_t          strb_o
);
  logic is_ro, is_wo;

  always_comb begin
    is_ro = 1'b0;
    is_wo = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx_i == chan_base(c) + OFF_STAT || idx_i == chan_base(c) + OFF_RAW) is_ro = 1'b1;
      if (idx_i == chan_base(c) + OFF_ENCLR) is_wo = 1'b1;
    end
    if (idx_i == IX_SOFT_CLR) is_wo = 1'b1;
  end

  always_comb begin
    strb_o = '0;
    if (req_i && we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx_i == chan_base(c) + OFF_ENSET) strb_o.en_set[c] = 1'b1;
        if (idx_i == chan_base(c) + OFF_ENCLR) strb_o.en_clr[c] = 1'b1;
      end
      strb_o.soft_set = (idx_i == IX_SOFT_SET) && wbit0_i;
      strb_o.soft_clr = (idx_i == IX_SOFT_CLR) && wbit0_i;
      strb_o.bad      = is_ro;
    end else if (req_i) begin
      strb_o.bad = is_wo;
    end
  end
endmodule

// File: rtl/lvl_intc_mask.sv
module lvl_intc_mask #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (set_i) mask_o <= mask_o | bits_i;
    else if (clr_i) mask_o <= mask_o & ~bits_i;
  end

  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));
  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((mask_o & $past(bits_i)) == '0));
  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_o));
endmodule

// File: rtl/lvl_intc_rdmux.sv
module lvl_intc_rdmux
  import lvl_intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic                     bad_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [W-1:0]             level_i,
  input  logic [NUM_CH-1:0][W-1:0] mask_i,
  input  logic                     soft_i,
  output logic [W-1:0]             rdata_o,
  output logic                     rvalid_o,
  output logic                     err_o
);
  logic [W-1:0] val;

  always_comb begin
    val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx_i == chan_base(c) + OFF_STAT)  val = level_i & mask_i[c];
      if (idx_i == chan_base(c) + OFF_RAW)   val = level_i;
      if (idx_i == chan_base(c) + OFF_ENSET) val = mask_i[c];
    end
    if (idx_i == IX_SOFT_SET) val = {{(W-1){1'b0}}, soft_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      err_o    <= bad_i;
      if (rd_i) rdata_o <= val;
    end
  end

  // R10
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  // R9
  bad_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && bad_i) |=> (err_o && rdata_o == '0));
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               err_o,
  output logic               irq_o,
  output logic               fiq_o
);
  strobe_t                         strb;
  logic                            soft_q;
  logic [NUM_SRC-1:0]              level;
  logic [NUM_CH-1:0][NUM_SRC-1:0]  mask;
  logic [NUM_CH-1:0]               req_out;

  lvl_intc_decode u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .idx_i   (idx_i),
    .wbit0_i (wdata_i[0]),
    .strb_o  (strb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            soft_q <= 1'b0;
    else if (strb.soft_set) soft_q <= 1'b1;
    else if (strb.soft_clr) soft_q <= 1'b0;
  end

  assign level = irq_lines_i | {{(NUM_SRC-1){1'b0}}, soft_q};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lvl_intc_mask #(.W(NUM_SRC)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (strb.en_set[c]),
      .clr_i  (strb.en_clr[c]),
      .bits_i (wdata_i),
      .mask_o (mask[c])
    );
    assign req_out[c] = |(level & mask[c]);
  end

  assign irq_o = req_out[0];
  assign fiq_o = req_out[1];

  lvl_intc_rdmux #(.W(NUM_SRC)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (req_i && !we_i),
    .bad_i    (strb.bad),
    .idx_i    (idx_i),
    .level_i  (level),
    .mask_i   (mask),
    .soft_i   (soft_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .err_o    (err_o)
  );

  // R2
  irq_masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask[0] == '0) |-> !irq_o);
  // R2
  fiq_masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask[1] == '0) |-> !fiq_o);
  // R6
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx_i == IX_SOFT_CLR && wdata_i[0]) |=> !soft_q);
  // R8
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (idx_i == 4'd0 || idx_i == 4'd1 || idx_i == 4'd8 || idx_i == 4'd9))
      |=> ($stable(mask) && $stable(soft_q) && err_o));
endmodule

// File: tb/lvl_intc_test.sv
`timescale 1ns/1ps
module lvl_intc_test;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] irq_lines_i = '0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [3:0]   idx_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         rvalid_o, err_o, irq_o, fiq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0] m_irq = '0, m_fiq = '0;
  logic         m_soft = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lvl_intc #(.NUM_SRC(W)) uut (.*);

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", r, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] m_level(input logic [W-1:0] lines);
    return lines | {{(W-1){1'b0}}, m_soft};
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [3:0] ix, input logic [W-1:0] lines);
    case (ix)
      4'd0:  return m_level(lines) & m_irq;
      4'd1:  return m_level(lines);
      4'd2:  return m_irq;
      4'd4:  return {{(W-1){1'b0}}, m_soft};
      4'd8:  return m_level(lines) & m_fiq;
      4'd9:  return m_level(lines);
      4'd10: return m_fiq;
      default: return '0;
    endcase
  endfunction

  function automatic bit exp_bad(input logic we, input logic [3:0] ix);
    if (we) return ix == 4'd0 || ix == 4'd1 || ix == 4'd8 || ix == 4'd9;
    return ix == 4'd3 || ix == 4'd5 || ix == 4'd11;
  endfunction

  task automatic access(input logic we, input logic [3:0] ix, input logic [W-1:0] d,
                        input logic [W-1:0] lines, input string tag);
    logic [W-1:0] e_rd;
    bit e_bad;
    @(negedge clk_i);
    irq_lines_i = lines; req_i = 1'b1; we_i = we; idx_i = ix; wdata_i = d;
    e_rd  = exp_read(ix, lines);
    e_bad = exp_bad(we, ix);
    @(posedge clk_i); #1;
    req_i = 1'b0;
    if (we) begin
      case (ix)
        4'd2:  m_irq = m_irq | d;
        4'd3:  m_irq = m_irq & ~d;
        4'd4:  if (d[0]) m_soft = 1'b1;
        4'd5:  if (d[0]) m_soft = 1'b0;
        4'd10: m_fiq = m_fiq | d;
        4'd11: m_fiq = m_fiq & ~d;
        default: ;
      endcase
    end
    chk({tag, " R10 rvalid"}, W'(rvalid_o), W'(!we));
    if (!we) chk({tag, " rdata"}, rdata_o, e_rd);
    chk({tag, " R8/R9 err"}, W'(err_o), W'(e_bad));
    chk({tag, " R2 irq"}, W'(irq_o), W'(|(m_level(lines) & m_irq)));
    chk({tag, " R2 fiq"}, W'(fiq_o), W'(|(m_level(lines) & m_fiq)));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #12 rst_ni = 1'b1;
    #1;
    // R7 reset state
    chk("R7 irq", W'(irq_o), '0);
    chk("R7 fiq", W'(fiq_o), '0);
    chk("R7 err", W'(err_o), '0);
    chk("R7 rvalid", W'(rvalid_o), '0);
    access(0, 4'd2, '0, '0, "R7 irq mask");
    access(0, 4'd10, '0, '0, "R7 fiq mask");
    // R3 set, R2 output
    access(1, 4'd2, 32'h0000_0020, 32'h0000_0020, "R3 set");
    chk("R2 irq high", W'(irq_o), 32'd1);
    chk("R2 fiq low", W'(fiq_o), 32'd0);
    access(0, 4'd2, '0, 32'h0000_0020, "R3 read");
    // R4 fiq mask set/clear
    access(1, 4'd10, 32'h8000_0001, 32'h8000_0000, "R4 set");
    access(1, 4'd11, 32'h0000_0001, 32'h8000_0000, "R4 clr");
    access(0, 4'd10, '0, 32'h8000_0000, "R4 read");
    // R5 status
    access(0, 4'd0, '0, 32'hFFFF_FFFF, "R5 irq stat");
    access(0, 4'd8, '0, 32'hFFFF_FFFF, "R5 fiq stat");
    // R6 / R1 software bit on line 0
    access(1, 4'd4, 32'h1, '0, "R6 soft set");
    access(0, 4'd1, '0, '0, "R1 raw soft");
    access(0, 4'd4, '0, '0, "R6 soft read");
    access(1, 4'd2, 32'h1, '0, "R6 enable line0");
    chk("R6 irq by soft", W'(irq_o), 32'd1);
    access(1, 4'd4, 32'h2, '0, "R6 set bit0 low");
    access(1, 4'd5, 32'h1, '0, "R6 soft clr");
    access(0, 4'd9, '0, 32'h0000_0001, "R1 raw ext");
    // R8 read-only writes ignored
    access(1, 4'd1, 32'hFFFF_FFFF, '0, "R8 wr raw");
    access(1, 4'd8, 32'hFFFF_FFFF, '0, "R8 wr stat");
    access(0, 4'd2, '0, '0, "R8 irq mask kept");
    access(0, 4'd10, '0, '0, "R8 fiq mask kept");
    // R9 write-only reads
    access(0, 4'd3, '0, '0, "R9 rd enclr");
    access(0, 4'd5, '0, '0, "R9 rd softclr");
    access(0, 4'd11, '0, '0, "R9 rd fiq enclr");
    // R10 unmapped
    access(1, 4'd7, 32'hFFFF_FFFF, '0, "R10 wr unmapped");
    access(0, 4'd7, '0, '0, "R10 rd unmapped");
    access(0, 4'd14, '0, '0, "R10 rd unmapped hi");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] ix;
      logic [W-1:0] d, ln;
      ix = 4'($urandom_range(0, 15));
      d  = $urandom;
      ln = $urandom & $urandom;
      if (($urandom & 3) == 0) ln = '0;
      access(1'($urandom), ix, d, ln, "rand");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule